// File: doc/BRIEF.md
# Registered Four-Bit Dual-Mode Arithmetic/Logic Unit

This block is a small datapath unit. It combines two 4-bit operands under one of thirty-two fixed functions. A mode bit splits the function space into two halves. In logic mode a 4-bit select code picks one of sixteen bitwise operations, and no carry ripples between bits. In arithmetic mode the same select code picks one of sixteen sum forms. Each form is some mix of A, B, A AND B, A AND NOT B, A OR B, A OR NOT B and the all-ones constant. A ripple-carry chain adds the two terms together with the carry input. It returns a carry output, which is the fifth bit of that sum.

Operands and controls are captured in an input register on every rising clock edge. The registered result appears one edge later. A new operation can be issued on every cycle, and each result leaves two edges after its inputs were presented.

Top module: `alu4_dual`

## Requirements
- R1: While `rst_n` is low, the input register and the output register are cleared asynchronously, so `f_o` and `cout_o` read 0. The first result after release comes from the cleared input register, which holds arithmetic mode, code 0, A=0 and carry-in 0, and so also reads 0.
- R2: Inputs present at rising edge k produce their `f_o`/`cout_o` after rising edge k+1. The outputs do not change while the inputs stay constant.
- R3: With `mode_i`=1, `f_o` for `sel_i` 0..15 is, in code order: NOT A, NOR, (NOT A) AND B, 0000, NAND, NOT B, XOR, A AND NOT B, (NOT A) OR B, XNOR, B, AND, 1111, A OR NOT B, OR, A.
- R4: With `mode_i`=1, `cout_o` is 0 and `cin_i` has no effect on `f_o`.
- R5: With `mode_i`=0, `f_o` is the low 4 bits of base + `cin_i`. In code order, base is: A; A OR B; A OR NOT B; 1111; A + (A AND NOT B); (A OR B) + (A AND NOT B); A + NOT B; (A AND NOT B) + 1111; A + (A AND B); A + B; (A OR NOT B) + (A AND B); (A AND B) + 1111; A + A; (A OR B) + A; (A OR NOT B) + A; A + 1111.
- R6: With `mode_i`=0, `cout_o` is bit 4 of the 5-bit sum in R5. For example, A=B=1111 with code 9 and carry-in 1 gives `f_o`=1111 and `cout_o`=1.
- R7: With `mode_i`=0 and code 3 (the minus-one form), the result is 01111 when carry-in is 0. It is 10000 (`f_o`=0000, `cout_o`=1) when carry-in is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| mode_i | input | 1 | 1 = logic group, 0 = arithmetic group |
| sel_i | input | 4 | Function code within the group |
| cin_i | input | 1 | Carry input, used in arithmetic mode only |
| f_o | output | 4 | Registered result |
| cout_o | output | 1 | Registered carry output, 0 in logic mode |

## Verification
Every result is due two rising edges after its inputs were presented. One edge is spent in the input register and one in the output register. The bench applies a fresh vector at each falling edge and queues its expected value. It pops and compares that value at the falling edge that follows the second rising edge, so a design with one edge of latency, or with three, misaligns and is caught. The reset checks sample between edges: once right after an asynchronous assertion, and again on the first result after release, which must come from the cleared input register rather than from the operands still being driven.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             logic_mode;
    logic [SEL_W-1:0] sel;
    logic             cin;
  } alu_ctl_t;
endpackage

// File: rtl/alu4_in_stage.sv
module alu4_in_stage
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_ctl_t     ctl_i,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output alu_ctl_t     ctl_q
);
  logic [W-1:0] a_d;
  logic [W-1:0] b_d;
  alu_ctl_t     ctl_d;

  // next-state: capture every cycle
  always_comb begin
    a_d   = a_i;
    b_d   = b_i;
    ctl_d = ctl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      ctl_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/alu4_operand_gen.sv
module alu4_operand_gen
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     x,
  output logic [W-1:0]     y
);
  // Per bit: x gathers A with optional B / NOT B terms (sel[1:0]),
  // y gathers optional A AND B / A AND NOT B terms (sel[3:2]).
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign x[i] = a[i] | (sel[0] & b[i]) | (sel[1] & ~b[i]);
    assign y[i] = (sel[3] & a[i] & b[i]) | (sel[2] & a[i] & ~b[i]);
  end
endmodule

// File: rtl/alu4_ripple.sv
module alu4_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]     = x[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
  end

  assign cout = carry[W];
endmodule

// File: rtl/alu4_dual.sv
module alu4_dual
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             cin_i,
  output logic [W-1:0]     f_o,
  output logic             cout_o
);
  alu_ctl_t     ctl_in;
  alu_ctl_t     ctl_q;
  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic [W-1:0] x;
  logic [W-1:0] y;
  logic [W-1:0] sum;
  logic         sum_cout;
  logic [W-1:0] f_d;
  logic         cout_d;

  assign ctl_in = '{logic_mode: mode_i, sel: sel_i, cin: cin_i};

  alu4_in_stage #(.W(W)) u_in (
    .clk  (clk),
    .rst_n(rst_n),
    .a_i  (a_i),
    .b_i  (b_i),
    .ctl_i(ctl_in),
    .a_q  (a_q),
    .b_q  (b_q),
    .ctl_q(ctl_q)
  );

  alu4_operand_gen #(.W(W)) u_ops (
    .a  (a_q),
    .b  (b_q),
    .sel(ctl_q.sel),
    .x  (x),
    .y  (y)
  );

  alu4_ripple #(.W(W)) u_add (
    .x   (x),
    .y   (y),
    .cin (ctl_q.cin),
    .sum (sum),
    .cout(sum_cout)
  );

  // Logic group reuses the operand terms: no carries, inverted half-sum.
  always_comb begin
    if (ctl_q.logic_mode) begin
      f_d    = ~(x ^ y);
      cout_d = 1'b0;
    end else begin
      f_d    = sum;
      cout_d = sum_cout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_o    <= '0;
      cout_o <= 1'b0;
    end else begin
      f_o    <= f_d;
      cout_o <= cout_d;
    end
  end
endmodule

// File: rtl/alu4_dual_chk.sv
module alu4_dual_chk
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     a_i,
  input logic [W-1:0]     b_i,
  input logic             mode_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             cin_i,
  input logic [W-1:0]     f_o,
  input logic             cout_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (f_o == '0 && cout_o == 1'b0));

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) &&
     $past({a_i, b_i, mode_i, sel_i, cin_i}, 2) == $past({a_i, b_i, mode_i, sel_i, cin_i}, 3))
    |-> ($stable(f_o) && $stable(cout_o)));

  p_logic_xor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && $past(mode_i, 2) && $past(sel_i, 2) == 4'd6)
    |-> f_o == ($past(a_i, 2) ^ $past(b_i, 2)));

  p_logic_nocarry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && $past(mode_i, 2)) |-> cout_o == 1'b0);

  p_add_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && !$past(mode_i, 2) && $past(sel_i, 2) == 4'd9)
    |-> {cout_o, f_o} == ({1'b0, $past(a_i, 2)} + {1'b0, $past(b_i, 2)} +
                          {{W{1'b0}}, $past(cin_i, 2)}));

  p_minus_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && !$past(mode_i, 2) && $past(sel_i, 2) == 4'd3)
    |-> {cout_o, f_o} == ({1'b0, {W{1'b1}}} + {{W{1'b0}}, $past(cin_i, 2)}));
endmodule

bind alu4_dual alu4_dual_chk #(.W(W)) u_chk (.*);

// File: tb/alu4_dual_tb.sv
module alu4_dual_tb;
  logic       clk;
  logic       rst_n;
  logic [3:0] a_i;
  logic [3:0] b_i;
  logic       mode_i;
  logic [3:0] sel_i;
  logic       cin_i;
  logic [3:0] f_o;
  logic       cout_o;

  int checks;
  int fails;
  bit done;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  alu4_dual u_dut (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .mode_i(mode_i),
    .sel_i(sel_i), .cin_i(cin_i), .f_o(f_o), .cout_o(cout_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [4:0] model(int m, int s, int a, int b, int c);
    int nb;
    int r;
    nb = (~b) & 15;
    if (m == 1) begin
      case (s)
        0:  r = (~a) & 15;
        1:  r = (~(a | b)) & 15;
        2:  r = ((~a) & b) & 15;
        3:  r = 0;
        4:  r = (~(a & b)) & 15;
        5:  r = nb;
        6:  r = a ^ b;
        7:  r = a & nb;
        8:  r = ((~a) | b) & 15;
        9:  r = (~(a ^ b)) & 15;
        10: r = b;
        11: r = a & b;
        12: r = 15;
        13: r = a | nb;
        14: r = a | b;
        default: r = a;
      endcase
    end else begin
      case (s)
        0:  r = a;
        1:  r = a | b;
        2:  r = a | nb;
        3:  r = 15;
        4:  r = a + (a & nb);
        5:  r = (a | b) + (a & nb);
        6:  r = a + nb;
        7:  r = (a & nb) + 15;
        8:  r = a + (a & b);
        9:  r = a + b;
        10: r = (a | nb) + (a & b);
        11: r = (a & b) + 15;
        12: r = a + a;
        13: r = (a | b) + a;
        14: r = (a | nb) + a;
        default: r = a + 15;
      endcase
      r = r + c;
    end
    return r[4:0];
  endfunction

  task automatic check(input logic [4:0] exp, input string tag);
    checks++;
    if ({cout_o, f_o} !== exp) begin
      fails++;
      $display("FAIL %s: got cout=%b f=%b, expected cout=%b f=%b",
               tag, cout_o, f_o, exp[4], exp[3:0]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; a_i = '0; b_i = '0; mode_i = 1'b0; sel_i = '0; cin_i = 1'b0;
    repeat (3) @(negedge clk);
    check(5'd0, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(5'd0, "R1 idle after release");

    // Full sweep: one vector per cycle, result due two rising edges later (R2).
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            for (int c = 0; c < 2; c++) begin
              @(negedge clk);
              if (exp_q.size() >= 2) check(exp_q.pop_front(), tag_q.pop_front());
              a_i = 4'(a); b_i = 4'(b); mode_i = m[0]; sel_i = 4'(s); cin_i = c[0];
              exp_q.push_back(model(m, s, a, b, c));
              if (m == 1)      tag_q.push_back($sformatf("R2 R3 R4 logic s=%0d a=%0d b=%0d c=%0d", s, a, b, c));
              else if (s == 3) tag_q.push_back($sformatf("R2 R7 minus one a=%0d b=%0d c=%0d", a, b, c));
              else             tag_q.push_back($sformatf("R2 R5 R6 arith s=%0d a=%0d b=%0d c=%0d", s, a, b, c));
            end
    while (exp_q.size() > 0) begin
      @(negedge clk);
      check(exp_q.pop_front(), tag_q.pop_front());
    end

    // Full-carry case, then asynchronous reset in mid-cycle.
    a_i = 4'hF; b_i = 4'hF; mode_i = 1'b0; sel_i = 4'd9; cin_i = 1'b1;
    repeat (3) @(negedge clk);
    check(5'b11111, "R6 full carry 15+15+1");
    check(5'b11111, "R2 held inputs keep result");
    #3 rst_n = 1'b0;
    #1 check(5'd0, "R1 async clear mid-cycle");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(5'd0, "R1 first result from cleared input register");
    @(negedge clk);
    check(5'b11111, "R2 operands return after reset");

    // Logic mode with carry-in toggled: cin must not matter (R4).
    mode_i = 1'b1; sel_i = 4'd12; a_i = 4'h3; b_i = 4'h5; cin_i = 1'b1;
    repeat (2) @(negedge clk);
    check(5'b01111, "R4 logic ones, cin=1");
    cin_i = 1'b0;
    repeat (2) @(negedge clk);
    check(5'b01111, "R4 logic ones, cin=0");
    finish_run();
  end
endmodule